// File: doc/BRIEF.md
# Programmable Permutation Replacement Controller

This block holds the replacement state of one set in an A-way set-associative cache and names the way to refill when a lookup misses. The state is a total order of the A way indices. Position 0 is the front of the order and position A-1 is the back. The way at the back is always the victim.

Each access rewrites the order with a permutation read from a small table. The table has A+1 rows. A hit uses the row numbered by the current position of the way that was hit. A miss uses row A. So the replacement policy is just data. Least-recently-used, fill-order (FIFO), tree-like and grouped policies all run on the same datapath.

The table can be written one row at a time through a configuration port. It can also be filled in one cycle from a built-in LRU or FIFO image. Tag comparison, data arrays and the selection of one set among many are left to the surrounding cache.

Top module: `permrepl_top`

## Requirements
- R1: After reset, position p holds way p for every p, and the victim output reads way A-1. At every later time, the order holds each way exactly once, as long as the table holds only valid permutations.
- R2: The victim output is the way at position A-1 of the order as it stands after the most recent update.
- R3: The order changes only at a rising clock edge where the access strobe is high. In all other cycles it keeps its value, and the new order is visible from the cycle after the strobe.
- R4: On a hit, the controller uses the table row whose number is the current position of the hit way. A row is packed as A fields of log2(A) bits, where the field at bits [i*W +: W] is the destination position of the block that sits at position i. The new order is new[dest(i)] = old[i].
- R5: On a miss, the controller uses table row A, whatever the hit-way input holds.
- R6: The LRU image is loaded at reset and by a preset load with the select low. With this image, a hit at position h moves that block to position 0, moves each block at a position below h back by one, and leaves the blocks behind h where they are.
- R7: The FIFO image is loaded by a preset load with the select high. With this image, a hit leaves the order unchanged.
- R8: In both images, a miss moves the victim way to position 0 and moves every other block back by one. Starting from a known order, the block at 1-based position j is chosen as victim on exactly the (A-j+1)-th consecutive miss, and not before.
- R9: A configuration write puts the packed permutation into row cfg_idx (0 to A, with A being the miss row). A configuration write or a preset load that arrives in a cycle with the access strobe high is dropped, and the table keeps its contents.
- R10: A grouped policy can be loaded as a set of permutations. For 6 ways, this policy is LRU among three pairs of ways with LRU inside each pair, and a miss refills the back way of the least-recent pair. Once loaded, the controller tracks this policy exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one per cycle |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_way | input | W | Way that hit (ignored on a miss) |
| cfg_we | input | 1 | Table row write enable |
| cfg_idx | input | log2(A+1) | Row to write, A = miss row |
| cfg_perm | input | A*W | Packed destination positions |
| preset_load | input | 1 | Load a built-in image into the whole table |
| preset_fifo | input | 1 | Image select: 1 = FIFO, 0 = LRU |
| victim_way | output | W | Way at the back of the order |
| order_out | output | A*W | Current order, field p = way at position p |

## Verification
The bench builds the controller with A = 6, so every position is 3 bits wide and the table has seven rows. At that size, every hit position can be tried from a known order, and the eviction count can be measured for every starting position under both built-in images. Six ways also divide into three pairs, which makes the grouped LRU policy of R10 possible. That policy is checked against a separate list-of-lists model that does not use permutations at all. Long pseudo-random runs of mixed hits and misses follow, under the LRU image, the FIFO image and the grouped policy.

// File: rtl/permrepl_pkg.sv
package permrepl_pkg;

    // Built-in table images
    typedef enum logic {
        PRE_LRU  = 1'b0,
        PRE_FIFO = 1'b1
    } preset_e;

    // Control flags of one access
    typedef struct packed {
        logic fire;
        logic hit;
    } acc_ctl_t;

    // Width of a field that holds values 0..n-1 (at least one bit)
    function automatic int field_bits(int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Destination position of the block at position pos, for table row 'row'.
    // Row 'ways' is the miss row.
    function automatic int preset_dest(preset_e p, int row, int pos, int ways);
        if (row == ways) begin
            return (pos == ways - 1) ? 0 : pos + 1;
        end
        if (p == PRE_FIFO) begin
            return pos;
        end
        if (pos < row) begin
            return pos + 1;
        end
        if (pos == row) begin
            return 0;
        end
        return pos;
    endfunction

endpackage

// File: rtl/permrepl_table.sv
module permrepl_table
    import permrepl_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int PW   = 3,
    parameter int IW   = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          lock,
    input  logic                          cfg_we,
    input  logic [IW-1:0]                 cfg_idx,
    input  logic [WAYS*PW-1:0]            cfg_perm,
    input  logic                          preset_load,
    input  logic                          preset_fifo,
    output logic [(WAYS+1)*WAYS*PW-1:0]   tbl_flat
);
    localparam int ROWW = WAYS * PW;
    localparam int TBLW = (WAYS + 1) * ROWW;

    logic [TBLW-1:0] tbl_q;

    function automatic logic [TBLW-1:0] build_image(preset_e p);
        logic [TBLW-1:0] img;
        img = '0;
        for (int r = 0; r <= WAYS; r++) begin
            for (int i = 0; i < WAYS; i++) begin
                img[(r*WAYS+i)*PW +: PW] = PW'(preset_dest(p, r, i, WAYS));
            end
        end
        return img;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= build_image(PRE_LRU);
        end else if (!lock) begin
            if (preset_load) begin
                tbl_q <= build_image(preset_e'(preset_fifo));
            end else if (cfg_we && (int'(cfg_idx) <= WAYS)) begin
                tbl_q[int'(cfg_idx)*ROWW +: ROWW] <= cfg_perm;
            end
        end
    end

    assign tbl_flat = tbl_q;

endmodule

// File: rtl/permrepl_locate.sv
module permrepl_locate #(
    parameter int WAYS = 8,
    parameter int PW   = 3
) (
    input  logic [WAYS*PW-1:0] order,
    input  logic [PW-1:0]      key,
    output logic [PW-1:0]      pos
);
    logic [WAYS-1:0] match;

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_cmp
            assign match[g] = (order[g*PW +: PW] == key);
        end
    endgenerate

    always_comb begin
        pos = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) begin
                pos = PW'(i);
            end
        end
    end

endmodule

// File: rtl/permrepl_apply.sv
module permrepl_apply #(
    parameter int WAYS = 8,
    parameter int PW   = 3
) (
    input  logic [WAYS*PW-1:0] order,
    input  logic [WAYS*PW-1:0] perm,
    output logic [WAYS*PW-1:0] next_order
);
    always_comb begin
        next_order = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (int'(perm[i*PW +: PW]) < WAYS) begin
                next_order[int'(perm[i*PW +: PW])*PW +: PW] = order[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/permrepl_top.sv
module permrepl_top
    import permrepl_pkg::*;
#(
    parameter  int WAYS = 8,
    localparam int PW   = field_bits(WAYS),
    localparam int IW   = field_bits(WAYS + 1),
    localparam int ROWW = WAYS * PW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic            acc_hit,
    input  logic [PW-1:0]   acc_way,
    input  logic            cfg_we,
    input  logic [IW-1:0]   cfg_idx,
    input  logic [ROWW-1:0] cfg_perm,
    input  logic            preset_load,
    input  logic            preset_fifo,
    output logic [PW-1:0]   victim_way,
    output logic [ROWW-1:0] order_out
);
    localparam int TBLW = (WAYS + 1) * ROWW;

    function automatic logic [ROWW-1:0] identity_order();
        logic [ROWW-1:0] o;
        for (int p = 0; p < WAYS; p++) begin
            o[p*PW +: PW] = PW'(p);
        end
        return o;
    endfunction

    acc_ctl_t        ctl;
    logic [TBLW-1:0] tbl_flat;
    logic [ROWW-1:0] order_q;
    logic [ROWW-1:0] order_d;
    logic [ROWW-1:0] row_sel;
    logic [PW-1:0]   hit_pos;
    logic [IW-1:0]   row_idx;

    assign ctl = '{fire: acc_valid, hit: acc_hit};

    permrepl_table #(.WAYS(WAYS), .PW(PW), .IW(IW)) u_table (
        .clk        (clk),
        .rst        (rst),
        .lock       (ctl.fire),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_perm   (cfg_perm),
        .preset_load(preset_load),
        .preset_fifo(preset_fifo),
        .tbl_flat   (tbl_flat)
    );

    permrepl_locate #(.WAYS(WAYS), .PW(PW)) u_locate (
        .order(order_q),
        .key  (acc_way),
        .pos  (hit_pos)
    );

    // Hit rows are numbered by position; the last row serves misses
    assign row_idx = ctl.hit ? IW'(hit_pos) : IW'(WAYS);
    assign row_sel = tbl_flat[int'(row_idx)*ROWW +: ROWW];

    permrepl_apply #(.WAYS(WAYS), .PW(PW)) u_apply (
        .order     (order_q),
        .perm      (row_sel),
        .next_order(order_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            order_q <= identity_order();
        end else if (ctl.fire) begin
            order_q <= order_d;
        end
    end

    assign order_out  = order_q;
    assign victim_way = order_q[(WAYS-1)*PW +: PW];

endmodule

// File: rtl/permrepl_chk.sv
module permrepl_chk
    import permrepl_pkg::*;
#(
    parameter int WAYS = 8
) (
    input logic                                       clk,
    input logic                                       rst,
    input logic                                       acc_valid,
    input logic                                       acc_hit,
    input logic [field_bits(WAYS)-1:0]                victim_way,
    input logic [WAYS*field_bits(WAYS)-1:0]           order_out,
    input logic [(WAYS+1)*WAYS*field_bits(WAYS)-1:0]  tbl
);
    localparam int PW   = field_bits(WAYS);
    localparam int ROWW = WAYS * PW;

    logic is_identity;
    logic each_once;
    logic miss_is_shift;

    always_comb begin
        is_identity = 1'b1;
        each_once   = 1'b1;
        for (int p = 0; p < WAYS; p++) begin
            if (int'(order_out[p*PW +: PW]) != p) begin
                is_identity = 1'b0;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            int n;
            n = 0;
            for (int p = 0; p < WAYS; p++) begin
                if (int'(order_out[p*PW +: PW]) == w) begin
                    n++;
                end
            end
            if (n != 1) begin
                each_once = 1'b0;
            end
        end
        miss_is_shift = 1'b1;
        for (int i = 0; i < WAYS; i++) begin
            if (int'(tbl[WAYS*ROWW + i*PW +: PW]) != ((i == WAYS - 1) ? 0 : i + 1)) begin
                miss_is_shift = 1'b0;
            end
        end
    end

    // R1: the order is the identity right after reset
    p_reset_order_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> is_identity);

    // R1: every way appears once in the order
    p_order_perm_r1: assert property (@(posedge clk) disable iff (rst)
        each_once);

    // R3: the order holds when there is no access
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> $stable(order_out));

    // R9: the table is frozen across an access cycle
    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> $stable(tbl));

    // R8: with the shifting miss row, the refilled way moves to the front
    p_miss_front_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_hit && miss_is_shift) |=> (order_out[PW-1:0] == $past(victim_way)));

endmodule

bind permrepl_top permrepl_chk #(.WAYS(WAYS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_hit   (acc_hit),
    .victim_way(victim_way),
    .order_out (order_out),
    .tbl       (tbl_flat)
);

// File: tb/tb_permrepl_top.sv
`timescale 1ns/1ps
module tb_permrepl_top;
    localparam int A  = 6;
    localparam int PW = 3;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            acc_valid = 1'b0;
    logic            acc_hit = 1'b0;
    logic [PW-1:0]   acc_way = '0;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [A*PW-1:0] cfg_perm = '0;
    logic            preset_load = 1'b0;
    logic            preset_fifo = 1'b0;
    logic [PW-1:0]   victim_way;
    logic [A*PW-1:0] order_out;

    permrepl_top #(.WAYS(A)) dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_perm(cfg_perm),
        .preset_load(preset_load), .preset_fifo(preset_fifo),
        .victim_way(victim_way), .order_out(order_out)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int model[A];
    int gl[3];
    int inner[3][2];
    int unsigned lcg = 32'h1234_5678;
    bit fifo_mode = 1'b0;

    function automatic int ord(int p);
        return int'(order_out[p*PW +: PW]);
    endfunction

    function automatic int unsigned rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg >> 8;
    endfunction

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_order(string tag);
        for (int p = 0; p < A; p++) begin
            check_int(tag, ord(p), model[p]);
        end
        check_int({tag, " R2 victim"}, int'(victim_way), model[A-1]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < A; p++) model[p] = p;
        fifo_mode = 1'b0;
    endtask

    task automatic access(bit hit, int way);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_hit   = hit;
        acc_way   = PW'(way);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic load_preset(bit fifo);
        @(negedge clk);
        preset_load = 1'b1;
        preset_fifo = fifo;
        @(negedge clk);
        preset_load = 1'b0;
        fifo_mode = fifo;
    endtask

    task automatic write_row(int idx, logic [A*PW-1:0] perm);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_idx  = IW'(idx);
        cfg_perm = perm;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int find_pos(int w);
        for (int p = 0; p < A; p++) if (model[p] == w) return p;
        return 0;
    endfunction

    task automatic to_front(int p);
        int w;
        w = model[p];
        for (int k = p; k > 0; k--) model[k] = model[k-1];
        model[0] = w;
    endtask

    // Model step for the LRU or FIFO image
    task automatic model_step(bit hit, int way);
        if (!hit) to_front(A - 1);
        else if (!fifo_mode) to_front(find_pos(way));
    endtask

    // Grouped policy model: three pairs, LRU over pairs and inside each pair
    task automatic nest_init();
        for (int g = 0; g < 3; g++) begin
            gl[g] = g;
            inner[g][0] = 2 * g;
            inner[g][1] = 2 * g + 1;
        end
    endtask

    task automatic nest_touch(int w);
        int grp;
        int gp;
        int t;
        grp = 0;
        for (int g = 0; g < 3; g++) begin
            if (inner[g][0] == w || inner[g][1] == w) grp = g;
        end
        if (inner[grp][1] == w) begin
            t = inner[grp][0];
            inner[grp][0] = w;
            inner[grp][1] = t;
        end
        gp = 0;
        for (int k = 0; k < 3; k++) if (gl[k] == grp) gp = k;
        for (int k = gp; k > 0; k--) gl[k] = gl[k-1];
        gl[0] = grp;
        for (int p = 0; p < A; p++) model[p] = inner[gl[p/2]][p%2];
    endtask

    function automatic logic [A*PW-1:0] nest_row(int h);
        logic [A*PW-1:0] r;
        int d;
        for (int i = 0; i < A; i++) begin
            if (i == h) d = 0;
            else if (i / 2 == h / 2) d = 1;
            else if (i / 2 < h / 2) d = i + 2;
            else d = i;
            r[i*PW +: PW] = PW'(d);
        end
        return r;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int evict_at;
        int target;
        int r;
        logic [A*PW-1:0] ident;

        // R1: reset state
        do_reset();
        check_order("R1 reset order");
        check_int("R1 reset victim", int'(victim_way), A - 1);

        // R3: no strobe, no change
        repeat (4) @(negedge clk);
        check_order("R3 idle hold");

        // R4 R6: every hit position from the identity order
        for (int h = 0; h < A; h++) begin
            do_reset();
            access(1'b1, model[h]);
            model_step(1'b1, model[h]);
            check_order("R4 R6 hit position sweep");
        end

        // R5 R6 R8: mixed run with the LRU image
        do_reset();
        for (int n = 0; n < 300; n++) begin
            r = int'(rnd());
            if (r % 4 != 0) begin
                access(1'b1, (r >> 4) % A);
                model_step(1'b1, (r >> 4) % A);
                check_order("R6 LRU run hit");
            end else begin
                access(1'b0, (r >> 4) % A);
                model_step(1'b0, 0);
                check_order("R5 R8 LRU run miss");
            end
        end

        // R7 R8: mixed run with the FIFO image
        load_preset(1'b1);
        for (int n = 0; n < 200; n++) begin
            r = int'(rnd());
            access(r % 3 != 0, (r >> 4) % A);
            model_step(r % 3 != 0, (r >> 4) % A);
            check_order("R7 FIFO run");
        end

        // R8: eviction count for every start position, both images
        for (int img = 0; img < 2; img++) begin
            for (int j = 1; j <= A; j++) begin
                do_reset();
                if (img == 1) load_preset(1'b1);
                for (int k = 0; k < A; k++) begin
                    access(1'b0, 0);
                    model_step(1'b0, 0);
                end
                check_order("R8 fill known order");
                target = ord(j - 1);
                evict_at = 0;
                for (int k = 1; k <= A + 1; k++) begin
                    if (evict_at == 0 && int'(victim_way) == target) evict_at = k;
                    access(1'b0, 0);
                end
                check_int("R8 misses to evict", evict_at, A - j + 1);
            end
        end

        // R9: writes and preset load dropped during an access
        do_reset();
        for (int i = 0; i < A; i++) ident[i*PW +: PW] = PW'(i);
        @(negedge clk);
        acc_valid = 1'b1; acc_hit = 1'b1; acc_way = PW'(model[3]);
        cfg_we = 1'b1; cfg_idx = IW'(2); cfg_perm = ident;
        preset_load = 1'b1; preset_fifo = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; cfg_we = 1'b0; preset_load = 1'b0; preset_fifo = 1'b0;
        model_step(1'b1, model[3]);
        check_order("R9 access beside config");
        access(1'b1, model[2]);
        model_step(1'b1, model[2]);
        check_order("R9 row 2 unchanged");
        access(1'b1, model[1]);
        model_step(1'b1, model[1]);
        check_order("R9 no FIFO image");

        // R9 R4: idle write of identity into row 2 freezes that hit
        write_row(2, ident);
        check_order("R9 write leaves order");
        access(1'b1, model[2]);
        check_order("R9 R4 written row applied");
        access(1'b1, model[4]);
        model_step(1'b1, model[4]);
        check_order("R9 other rows kept");

        // R10: grouped policy, three pairs
        do_reset();
        for (int h = 0; h < A; h++) write_row(h, nest_row(h));
        write_row(A, nest_row(A - 1));
        nest_init();
        for (int n = 0; n < 300; n++) begin
            r = int'(rnd());
            if (r % 4 != 0) begin
                access(1'b1, (r >> 4) % A);
                nest_touch((r >> 4) % A);
                check_order("R10 grouped hit");
            end else begin
                target = inner[gl[2]][1];
                check_int("R10 grouped victim", int'(victim_way), target);
                access(1'b0, 0);
                nest_touch(target);
                check_order("R10 grouped miss");
            end
        end

        summary();
        $finish;
    end

endmodule